// File: doc/BRIEF.md
# Data-Jitter Stress Pattern Generator

This block produces a repeating sequence of 24-bit two's-complement audio samples. The sequence is chosen to cause the worst data-dependent timing error on a band-limited serial audio cable. The sequence is 192 samples long. In the first half, a quarter-rate tone alternates between the pair 0xC00000 and the pair 0x400000. In the second half, the same tone is offset by minus one LSB, so the 22 lower bits all flip together once per half-cycle. At a 48 kHz sample rate this gives a 12 kHz tone at -3.01 dBFS and a 250 Hz alternation of the low bits.

A frame formatter upstream of the line coder pulses `sampleStrobe` once per sample period. The block answers each accepted strobe by registering the next sample and presenting it to both channels: a left valid pulse first, then a right valid pulse on the following cycle.

A "digital black" mode replaces every sample with zero, which gives a reference measurement without the modulation. A change of mode is only taken at the start of a cycle, so no partial cycle is ever emitted. A restart input forces the next sample to be the first sample of the cycle.

Top module: `jtest_pattern_gen`

## Requirements
- R1: After reset `sampleData` is 0, `leftValid` and `rightValid` are 0, the next sample produced is sample index 0, and the pattern mode (not black) is in force.
- R2: Sample index i in 0..95 has the value 0xC00000 when i mod 4 is 0 or 1, and 0x400000 when i mod 4 is 2 or 3.
- R3: Sample index i in 96..191 has the first-half value minus one: 0xBFFFFF when i mod 4 is 0 or 1, and 0x3FFFFF when i mod 4 is 2 or 3.
- R4: After index 191 the sequence continues at index 0, with no gap or repeat.
- R5: A strobe accepted at a clock edge loads the new sample and raises `leftValid` for exactly one cycle after that edge. `rightValid` follows for exactly the next cycle. `sampleData` holds the same value until the next accepted strobe.
- R6: A strobe is ignored while `leftValid` is 1. It produces no extra valid pulse and does not advance the sequence.
- R7: `restart` forces the next sample to be index 0. A strobe in the same cycle as `restart` is ignored, so no valid pulse follows it.
- R8: While black mode is in force, each sample is 0x000000, and the valid pulses and sequence position advance exactly as in pattern mode.
- R9: The `blackReq` level is sampled only when an index-0 sample is produced. That sampled level sets the mode for the entire 192-sample cycle, and a change made during a cycle has no effect until the next index-0 sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStrobe | input | 1 | Request for the next sample |
| restart | input | 1 | Return the sequence to index 0 |
| blackReq | input | 1 | Requested mode: 1 = all-zero samples, 0 = stress pattern |
| sampleData | output | 24 | Current sample, shared by both channels |
| leftValid | output | 1 | One-cycle pulse marking the sample for the left channel |
| rightValid | output | 1 | One-cycle pulse marking the sample for the right channel, one cycle after the left pulse |

## Verification
The hardest situation to bring about from the ports is a mode request that changes in the middle of a cycle, together with a wrap from index 191 to index 0. To reach it, the stimulus steps through whole cycles with random gaps between strobes and toggles `blackReq` at random sample positions. It then checks that the zeros start and stop exactly on index-0 samples. Directed steps also place a second strobe on the cycle where `leftValid` is high, and a strobe on the same cycle as `restart`. The model's sequence position then shows whether either strobe was wrongly accepted.

// File: rtl/jtp_pkg.sv
package jtp_pkg;

  typedef struct packed {
    logic load;     // register a new sample this cycle
    logic toneNeg;  // tone at its negative peak
    logic lowStep;  // second half: subtract one LSB
    logic zero;     // black mode in force for this sample
  } jtpStrobes_t;

endpackage

// File: rtl/jtp_control.sv
module jtp_control
  import jtp_pkg::*;
#(
  parameter int CYCLE_LEN   = 192,
  parameter int TONE_PERIOD = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleStrobe,
  input  logic        restart,
  input  logic        blackReq,
  output jtpStrobes_t strobes,
  output logic        leftValid,
  output logic        rightValid
);

  localparam int CNT_W    = $clog2(CYCLE_LEN);
  localparam int HALF     = CYCLE_LEN / 2;
  localparam int PAIR_BIT = $clog2(TONE_PERIOD) - 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CYCLE_LEN - 1);
  localparam logic [CNT_W-1:0] HALF_IDX = CNT_W'(HALF);

  logic [CNT_W-1:0] sampleIdx;
  logic             activeBlack;
  logic             accept;
  logic             atStart;

  assign accept  = sampleStrobe && !leftValid && !restart;
  assign atStart = (sampleIdx == '0);

  always_comb begin
    strobes.load    = accept;
    strobes.toneNeg = !sampleIdx[PAIR_BIT];
    strobes.lowStep = (sampleIdx >= HALF_IDX);
    strobes.zero    = atStart ? blackReq : activeBlack;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleIdx   <= '0;
      activeBlack <= 1'b0;
      leftValid   <= 1'b0;
      rightValid  <= 1'b0;
    end else begin
      leftValid  <= accept;
      rightValid <= leftValid;
      if (restart) begin
        sampleIdx <= '0;
      end else if (accept) begin
        sampleIdx <= (sampleIdx == LAST_IDX) ? '0 : sampleIdx + 1'b1;
        if (atStart) activeBlack <= blackReq;
      end
    end
  end

  // R4: the sequence position never leaves the cycle
  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    sampleIdx <= LAST_IDX);

  // R4: an accepted sample at the last index wraps to index 0
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (accept && sampleIdx == LAST_IDX) |=> sampleIdx == '0);

  // R5: the right pulse follows the left pulse
  a_r5_right_follows: assert property (@(posedge clk) disable iff (!rstN)
    leftValid |=> rightValid);

  // R5: the two pulses never overlap
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(leftValid && rightValid));

  // R6: a strobe during the left pulse leaves the position unchanged
  a_r6_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (leftValid && !restart) |=> $stable(sampleIdx));

  // R7: restart returns to index 0 and emits no pulse
  a_r7_restart: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (sampleIdx == '0) && !leftValid);

  // R9: the mode changes only when an index-0 sample is taken
  a_r9_mode_at_start: assert property (@(posedge clk) disable iff (!rstN)
    !(accept && atStart) |=> $stable(activeBlack));

endmodule

// File: rtl/jtp_datapath.sv
module jtp_datapath
  import jtp_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  jtpStrobes_t         strobes,
  output logic [SAMPLE_W-1:0] sampleData
);

  localparam logic [SAMPLE_W-1:0] TONE_POS = SAMPLE_W'(1) << (SAMPLE_W - 2);
  localparam logic [SAMPLE_W-1:0] TONE_NEG = ~TONE_POS + SAMPLE_W'(1);
  localparam logic [SAMPLE_W-1:0] LOW_ONES = (SAMPLE_W'(1) << (SAMPLE_W - 2)) - SAMPLE_W'(1);

  logic [SAMPLE_W-1:0] toneVal;
  logic [SAMPLE_W-1:0] nextVal;

  always_comb begin
    toneVal = strobes.toneNeg ? TONE_NEG : TONE_POS;
    nextVal = toneVal - (strobes.lowStep ? SAMPLE_W'(1) : SAMPLE_W'(0));
    if (strobes.zero) nextVal = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleData <= '0;
    end else if (strobes.load) begin
      sampleData <= nextVal;
    end
  end

  // R5: the sample holds between loads
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(sampleData));

  // R8: a black sample is all zeros
  a_r8_black_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.zero) |=> sampleData == '0);

  // R3: second-half samples carry all-ones low bits
  a_r3_low_ones: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.lowStep && !strobes.zero) |=>
      sampleData[SAMPLE_W-3:0] == LOW_ONES[SAMPLE_W-3:0]);

  // R2: first-half samples carry all-zero low bits
  a_r2_low_zeros: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.lowStep && !strobes.zero) |=>
      sampleData[SAMPLE_W-3:0] == '0);

endmodule

// File: rtl/jtest_pattern_gen.sv
module jtest_pattern_gen
  import jtp_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int CYCLE_LEN   = 192,
  parameter int TONE_PERIOD = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleStrobe,
  input  logic                restart,
  input  logic                blackReq,
  output logic [SAMPLE_W-1:0] sampleData,
  output logic                leftValid,
  output logic                rightValid
);

  jtpStrobes_t strobes;

  jtp_control #(
    .CYCLE_LEN  (CYCLE_LEN),
    .TONE_PERIOD(TONE_PERIOD)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .sampleStrobe(sampleStrobe),
    .restart     (restart),
    .blackReq    (blackReq),
    .strobes     (strobes),
    .leftValid   (leftValid),
    .rightValid  (rightValid)
  );

  jtp_datapath #(
    .SAMPLE_W(SAMPLE_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sampleData(sampleData)
  );

endmodule

// File: tb/jtest_pattern_gen_bench.sv
module jtest_pattern_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic        restart = 1'b0;
  logic        blackReq = 1'b0;
  logic [23:0] sampleData;
  logic        leftValid;
  logic        rightValid;

  int  nChecks = 0;
  int  nFails  = 0;
  int  cycles  = 0;
  int  mIdx    = 0;
  bit  curBlack = 1'b0;
  logic [23:0] lastExp = 24'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtest_pattern_gen u_jtest_pattern_gen (
    .clk         (clk),
    .rstN        (rstN),
    .sampleStrobe(sampleStrobe),
    .restart     (restart),
    .blackReq    (blackReq),
    .sampleData  (sampleData),
    .leftValid   (leftValid),
    .rightValid  (rightValid)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      nFails++;
      $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFails);
      $finish;
    end
  end

  function automatic logic [23:0] expSample(int idx, bit blk);
    logic [23:0] v;
    if (blk) return 24'h000000;
    v = ((idx % 4) < 2) ? 24'hC00000 : 24'h400000;
    if (idx >= 96) v = v - 24'h1;
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [23:0] act, logic [23:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one sample; extra=1 holds the strobe high during the left pulse (R6)
  task automatic doSample(bit extra, string req);
    bit eff;
    @(negedge clk) sampleStrobe = 1'b1;
    @(negedge clk) sampleStrobe = extra;
    eff = (mIdx == 0) ? blackReq : curBlack;
    if (mIdx == 0) curBlack = blackReq;
    lastExp = expSample(mIdx, eff);
    mIdx = (mIdx + 1) % 192;
    check(leftValid == 1'b1, {req, " R5 left pulse"}, 24'(leftValid), 24'h1);
    check(rightValid == 1'b0, {req, " R5 right low"}, 24'(rightValid), 24'h0);
    check(sampleData == lastExp, {req, " sample value"}, sampleData, lastExp);
    @(negedge clk) sampleStrobe = 1'b0;
    check(leftValid == 1'b0, {req, " R6 no second left pulse"}, 24'(leftValid), 24'h0);
    check(rightValid == 1'b1, {req, " R5 right pulse"}, 24'(rightValid), 24'h1);
    check(sampleData == lastExp, {req, " R5 data held"}, sampleData, lastExp);
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic doRestart(bit withStrobe);
    @(negedge clk) begin restart = 1'b1; sampleStrobe = withStrobe; end
    @(negedge clk) begin restart = 1'b0; sampleStrobe = 1'b0; end
    check(leftValid == 1'b0, "R7 strobe with restart ignored", 24'(leftValid), 24'h0);
    check(sampleData == lastExp, "R7 data unchanged by restart", sampleData, lastExp);
    mIdx = 0;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sampleData == 24'h0, "R1 reset data", sampleData, 24'h0);
    check(leftValid == 1'b0, "R1 reset left valid", 24'(leftValid), 24'h0);
    check(rightValid == 1'b0, "R1 reset right valid", 24'(rightValid), 24'h0);
    doSample(1'b0, "R1 first sample index 0");
    check(sampleData == 24'hC00000, "R2 first sample", sampleData, 24'hC00000);

    // two full cycles plus a bit: R2, R3, R4
    for (int i = 0; i < 400; i++) doSample(1'b0, (mIdx < 96) ? "R2" : "R3");

    // strobe held during left pulse: R6
    for (int i = 0; i < 6; i++) doSample(1'b1, "R6");

    // restart mid-cycle: R7
    doRestart(1'b0);
    doSample(1'b0, "R7 after restart");
    check(sampleData == 24'hC00000, "R7 first sample after restart", sampleData, 24'hC00000);
    for (int i = 0; i < 10; i++) doSample(1'b0, "R7");
    doRestart(1'b1);
    doSample(1'b0, "R7 restart with strobe");
    check(sampleData == 24'hC00000, "R7 index 0 after restart with strobe", sampleData, 24'hC00000);

    // black mode requested mid-cycle: R9, then R8
    for (int i = 0; i < 30; i++) doSample(1'b0, "R9 pre");
    blackReq = 1'b1;
    while (mIdx != 0) doSample(1'b0, "R9 request pending");
    for (int i = 0; i < 192; i++) begin
      if (i == 50 + ($urandom % 40)) blackReq = 1'b0;
      doSample(1'b0, "R8 black");
    end
    // back in pattern mode on wrap
    for (int i = 0; i < 100; i++) doSample(1'b0, "R9 pattern again");

    // black mode entered via restart
    blackReq = 1'b1;
    doRestart(1'b0);
    for (int i = 0; i < 8; i++) doSample(1'b0, "R8 black after restart");
    check(sampleData == 24'h0, "R8 black zero", sampleData, 24'h0);
    blackReq = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule